// File: doc/BRIEF.md
# Flash Block Write-Protection Lock Controller

This block holds the write-protection state of every erase block in a flash array and changes it on command. Each block is in one of three states: unlocked, locked, or lock-tight. Lock-tight is a sticky state. Ordinary lock and unlock commands cannot clear it, and only a reset releases it.

Software sets a lower and an upper block index through one shared write-data bus, then strobes a command code. The controller then walks the selected range one block per clock. At each block it applies the requested change unless the block's present state refuses it. It keeps a copy of the last state it wrote and ends the sweep with a one-cycle completion pulse and a sticky interrupt flag.

The block table spans `BLOCKS` entries, which must be a power of two so that address writes can be masked. Only the first `USED_BLOCKS` entries are populated. A sweep that reaches an unpopulated index stops there and reports a command error. A query port reads any entry at any time.

Top module: `wp_lock_ctrl`

## Requirements
- R1: Block states are one-hot: lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. `query_state` shows the entry at `query_idx` combinationally. Indices at or above `USED_BLOCKS` read 3'b000.
- R2: After reset every populated block is locked. `wp_status` is 16'h0002, and `busy`, `done`, `cmd_err` and `int_flag` are 0.
- R3: Four command codes are recognised:
  - 8'h23 unlocks blocks `start_addr` through `end_addr`, both ends included.
  - 8'h2A locks that range.
  - 8'h2C makes that range lock-tight.
  - 8'h27 unlocks blocks 0 through `USED_BLOCKS`-1.
  Any other code has no effect.
- R4: Unlock (8'h23, 8'h27) and lock (8'h2A) leave lock-tight blocks unchanged.
- R5: Lock-tight (8'h2C) leaves unlocked blocks unchanged. Locked and lock-tight blocks become lock-tight.
- R6: A write with `start_wr` stores `addr_wdata` masked with `BLOCKS`-1 into both `start_addr` and `end_addr`. A write with `end_wr` alone stores the masked value into `end_addr` only. If both strobes are high, `start_wr` wins.
- R7: When the sweep reaches an index at or above `USED_BLOCKS`, it sets `cmd_err` and ends at once. Blocks already processed keep their new state.
- R8: Each block that a command actually writes copies its new state into `wp_status` (zero-extended to 16 bits). Blocks that a command skips leave `wp_status` unchanged.
- R9: `busy` is high for one cycle per block index visited. `done` pulses for one cycle in the cycle after the last visit, together with setting `int_flag`. `int_ack` clears `int_flag` and `cmd_err`.
- R10: Command strobes that arrive while `busy` is high are ignored.
- R11: A range with start above end changes no block. It still gives `done` and `int_flag` in the cycle after the command, and `busy` never rises.

Port widths below use `IW` = log2(`BLOCKS`). `REG_W` is a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | Write `addr_wdata` to start and end index |
| end_wr | input | 1 | Write `addr_wdata` to end index |
| addr_wdata | input | REG_W | Index write data, masked to the table size |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| int_ack | input | 1 | Clear interrupt flag and command error |
| query_idx | input | IW | Table entry to observe |
| query_state | output | 3 | State of entry `query_idx` |
| start_addr | output | IW | Current start index |
| end_addr | output | IW | Current end index |
| wp_status | output | 16 | Last state written to a block |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Sticky out-of-range error |
| int_flag | output | 1 | Sticky completion flag |

## Verification
The command is accepted at the first rising edge where `cmd_valid` is high. A sweep over N indices shows `busy` during the N cycles after that edge. `done` and `int_flag` appear one cycle later, or straight after the accepting edge when the range is empty.

Index writes show up on `start_addr` and `end_addr` one edge after the strobe. `query_state` follows `query_idx` within the same cycle.

The bench drives every input at the falling edge and samples at the next falling edge. It counts the falling edges that see `busy` until `done` appears, and compares that count with the number of indices a reference model visits. Block states are read through the query port only after `done`.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

   typedef enum logic [2:0] {
      WP_TIGHT    = 3'b001,
      WP_LOCKED   = 3'b010,
      WP_UNLOCKED = 3'b100
   } wp_state_t;

   typedef enum logic [1:0] {
      OP_UNLOCK = 2'd0,
      OP_LOCK   = 2'd1,
      OP_TIGHT  = 2'd2
   } wp_op_t;

   localparam logic [7:0] CODE_UNLOCK_RANGE = 8'h23;
   localparam logic [7:0] CODE_UNLOCK_ALL   = 8'h27;
   localparam logic [7:0] CODE_LOCK_RANGE   = 8'h2A;
   localparam logic [7:0] CODE_TIGHT_RANGE  = 8'h2C;

   localparam int STATUS_W = 16;

   function automatic logic is_wp_cmd(input logic [7:0] code);
      return (code == CODE_UNLOCK_RANGE) || (code == CODE_UNLOCK_ALL) ||
             (code == CODE_LOCK_RANGE)   || (code == CODE_TIGHT_RANGE);
   endfunction

   function automatic wp_op_t code_to_op(input logic [7:0] code);
      case (code)
         CODE_LOCK_RANGE:  return OP_LOCK;
         CODE_TIGHT_RANGE: return OP_TIGHT;
         default:          return OP_UNLOCK;
      endcase
   endfunction

   function automatic logic [2:0] op_target(input wp_op_t op);
      case (op)
         OP_LOCK:  return WP_LOCKED;
         OP_TIGHT: return WP_TIGHT;
         default:  return WP_UNLOCKED;
      endcase
   endfunction

   // Lock-tight is sticky against unlock and lock.
   // Lock-tight may not be applied to an unlocked block.
   function automatic logic op_allowed(input wp_op_t op, input logic [2:0] cur);
      case (op)
         OP_TIGHT: return cur != WP_UNLOCKED;
         default:  return cur != WP_TIGHT;
      endcase
   endfunction

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
   parameter int REG_W = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_wr,
   input  logic             end_wr,
   input  logic [REG_W-1:0] wdata,
   output logic [IDX_W-1:0] start_idx,
   output logic [IDX_W-1:0] end_idx
);

   // Masking with (BLOCKS-1) keeps the low IDX_W bits.
   logic [IDX_W-1:0] masked;
   assign masked = wdata[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_idx <= '0;
         end_idx   <= '0;
      end else if (start_wr) begin
         start_idx <= masked;
         end_idx   <= masked;
      end else if (end_wr) begin
         end_idx   <= masked;
      end
   end

endmodule

// File: rtl/wp_state_table.sv
module wp_state_table
   import wp_lock_pkg::*;
#(
   parameter int BLOCKS      = 16,
   parameter int USED_BLOCKS = 12,
   parameter int IDX_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [2:0]       wr_state,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [2:0]       rd_state,
   input  logic [IDX_W-1:0] query_idx,
   output logic [2:0]       query_state
);

   logic [2:0] tbl [BLOCKS];

   for (genvar i = 0; i < BLOCKS; i++) begin : g_entry
      if (i < USED_BLOCKS) begin : g_live
         logic [2:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= WP_LOCKED;
            else if (wr_en && (wr_idx == IDX_W'(i)))
               q <= wr_state;
         end
         assign tbl[i] = q;
      end else begin : g_absent
         assign tbl[i] = 3'b000;
      end
   end

   assign rd_state    = tbl[rd_idx];
   assign query_state = tbl[query_idx];

endmodule

// File: rtl/wp_sweep.sv
module wp_sweep
   import wp_lock_pkg::*;
#(
   parameter int BLOCKS      = 16,
   parameter int USED_BLOCKS = 12,
   parameter int IDX_W       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [7:0]          cmd_code,
   input  logic                int_ack,
   input  logic [IDX_W-1:0]    start_idx,
   input  logic [IDX_W-1:0]    end_idx,
   input  logic [2:0]          rd_state,
   output logic [IDX_W-1:0]    rd_idx,
   output logic                wr_en,
   output logic [IDX_W-1:0]    wr_idx,
   output logic [2:0]          wr_state,
   output logic                busy,
   output logic                done,
   output logic                cmd_err,
   output logic                int_flag,
   output logic [STATUS_W-1:0] wp_status
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(USED_BLOCKS - 1);

   typedef enum logic {S_IDLE, S_RUN} sw_state_t;

   sw_state_t        st;
   logic [IDX_W-1:0] cur, hi;
   wp_op_t           op;
   logic             accept, all_sel, in_range, allow, at_last;
   logic [IDX_W-1:0] lo_sel, hi_sel;

   assign accept  = (st == S_IDLE) && cmd_valid && is_wp_cmd(cmd_code);
   assign all_sel = (cmd_code == CODE_UNLOCK_ALL);
   assign lo_sel  = all_sel ? '0 : start_idx;
   assign hi_sel  = all_sel ? LAST_IDX : end_idx;

   if (USED_BLOCKS == BLOCKS) begin : g_full
      assign in_range = 1'b1;
   end else begin : g_partial
      assign in_range = ({1'b0, cur} < (IDX_W+1)'(USED_BLOCKS));
   end

   assign rd_idx   = cur;
   assign allow    = op_allowed(op, rd_state);
   assign wr_state = op_target(op);
   assign wr_idx   = cur;
   assign wr_en    = (st == S_RUN) && in_range && allow;
   assign at_last  = (cur == hi);
   assign busy     = (st == S_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cur       <= '0;
         hi        <= '0;
         op        <= OP_UNLOCK;
         done      <= 1'b0;
         cmd_err   <= 1'b0;
         int_flag  <= 1'b0;
         wp_status <= STATUS_W'(WP_LOCKED);
      end else begin
         done <= 1'b0;
         if (int_ack) begin
            int_flag <= 1'b0;
            cmd_err  <= 1'b0;
         end
         if (accept) begin
            op  <= code_to_op(cmd_code);
            cur <= lo_sel;
            hi  <= hi_sel;
            if (lo_sel > hi_sel) begin
               done     <= 1'b1;
               int_flag <= 1'b1;
            end else begin
               st <= S_RUN;
            end
         end else if (st == S_RUN) begin
            if (!in_range) begin
               cmd_err  <= 1'b1;
               done     <= 1'b1;
               int_flag <= 1'b1;
               st       <= S_IDLE;
            end else begin
               if (wr_en)
                  wp_status <= STATUS_W'(wr_state);
               if (at_last) begin
                  done     <= 1'b1;
                  int_flag <= 1'b1;
                  st       <= S_IDLE;
               end else begin
                  cur <= cur + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
   import wp_lock_pkg::*;
#(
   parameter int BLOCKS      = 16,
   parameter int USED_BLOCKS = 12,
   parameter int REG_W       = 16,
   localparam int IW         = $clog2(BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_wr,
   input  logic             end_wr,
   input  logic [REG_W-1:0] addr_wdata,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_code,
   input  logic             int_ack,
   input  logic [IW-1:0]    query_idx,
   output logic [2:0]       query_state,
   output logic [IW-1:0]    start_addr,
   output logic [IW-1:0]    end_addr,
   output logic [15:0]      wp_status,
   output logic             busy,
   output logic             done,
   output logic             cmd_err,
   output logic             int_flag
);

   if (BLOCKS < 2 || (BLOCKS & (BLOCKS - 1)) != 0) begin : g_bad_blocks
      $error("BLOCKS must be a power of two of at least 2");
   end
   if (USED_BLOCKS < 1 || USED_BLOCKS > BLOCKS) begin : g_bad_used
      $error("USED_BLOCKS must lie in 1..BLOCKS");
   end
   if (REG_W < IW) begin : g_bad_regw
      $error("REG_W must hold a block index");
   end

   logic [IW-1:0] rd_idx, wr_idx;
   logic [2:0]    rd_state, wr_state;
   logic          wr_en;

   wp_range_regs #(.REG_W(REG_W), .IDX_W(IW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_wr  (start_wr),
      .end_wr    (end_wr),
      .wdata     (addr_wdata),
      .start_idx (start_addr),
      .end_idx   (end_addr)
   );

   wp_state_table #(.BLOCKS(BLOCKS), .USED_BLOCKS(USED_BLOCKS), .IDX_W(IW)) u_tbl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_state    (wr_state),
      .rd_idx      (rd_idx),
      .rd_state    (rd_state),
      .query_idx   (query_idx),
      .query_state (query_state)
   );

   wp_sweep #(.BLOCKS(BLOCKS), .USED_BLOCKS(USED_BLOCKS), .IDX_W(IW)) u_sweep (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .int_ack   (int_ack),
      .start_idx (start_addr),
      .end_idx   (end_addr),
      .rd_state  (rd_state),
      .rd_idx    (rd_idx),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_state  (wr_state),
      .busy      (busy),
      .done      (done),
      .cmd_err   (cmd_err),
      .int_flag  (int_flag),
      .wp_status (wp_status)
   );

endmodule

// File: rtl/wp_lock_ctrl_chk.sv
module wp_lock_ctrl_chk #(
   parameter int BLOCKS      = 16,
   parameter int USED_BLOCKS = 12,
   parameter int IW          = $clog2(BLOCKS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_wr,
   input logic [IW-1:0] query_idx,
   input logic [2:0]    query_state,
   input logic [IW-1:0] start_addr,
   input logic [IW-1:0] end_addr,
   input logic [15:0]   wp_status,
   input logic          busy,
   input logic          done,
   input logic          cmd_err,
   input logic          int_flag
);

   assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, query_idx} < (IW+1)'(USED_BLOCKS)) |-> ($countones(query_state) == 1));

   assert_start_copies_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (end_addr == start_addr));

   assert_status_only_in_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> $stable(wp_status));

   assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_err) |-> done);

   assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_int_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flag) |-> done);

endmodule

bind wp_lock_ctrl wp_lock_ctrl_chk #(.BLOCKS(BLOCKS), .USED_BLOCKS(USED_BLOCKS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_wr    (start_wr),
   .query_idx   (query_idx),
   .query_state (query_state),
   .start_addr  (start_addr),
   .end_addr    (end_addr),
   .wp_status   (wp_status),
   .busy        (busy),
   .done        (done),
   .cmd_err     (cmd_err),
   .int_flag    (int_flag)
);

// File: tb/wp_lock_ctrl_test.sv
module wp_lock_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NB   = 16;
   localparam int NU   = 12;
   localparam int IW   = 4;
   localparam int NVEC = 10;

   // Each entry is {start index, end index, command code}.
   localparam logic [23:0] VEC [NVEC] = '{
      {8'd2,  8'd5,  8'h23},
      {8'd3,  8'd3,  8'h2A},
      {8'd0,  8'd4,  8'h2C},
      {8'd0,  8'd15, 8'h23},
      {8'd8,  8'd9,  8'h2C},
      {8'd5,  8'd9,  8'h2A},
      {8'd5,  8'd6,  8'h2C},
      {8'd7,  8'd2,  8'h23},
      {8'd0,  8'd0,  8'h27},
      {8'd10, 8'd14, 8'h2A}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_wr = 1'b0, end_wr = 1'b0, cmd_valid = 1'b0, int_ack = 1'b0;
   logic [15:0]   addr_wdata = '0;
   logic [7:0]    cmd_code = '0;
   logic [IW-1:0] query_idx = '0;
   logic [2:0]    query_state;
   logic [IW-1:0] start_addr, end_addr;
   logic [15:0]   wp_status;
   logic          busy, done, cmd_err, int_flag;

   int n_checks = 0;
   int n_fail   = 0;

   logic [2:0]  exp_st [NB];
   logic [15:0] exp_status;

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_lock_ctrl #(.BLOCKS(NB), .USED_BLOCKS(NU), .REG_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
      .addr_wdata(addr_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .int_ack(int_ack), .query_idx(query_idx), .query_state(query_state),
      .start_addr(start_addr), .end_addr(end_addr), .wp_status(wp_status),
      .busy(busy), .done(done), .cmd_err(cmd_err), .int_flag(int_flag)
   );

   task automatic check(input logic ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_range(input int lo, input int hi);
      @(negedge clk); start_wr = 1'b1; addr_wdata = 16'(lo);
      @(negedge clk); start_wr = 1'b0; end_wr = 1'b1; addr_wdata = 16'(hi);
      @(negedge clk); end_wr = 1'b0;
   endtask

   // Pulse a command, then count busy cycles until done. Returns -1 on timeout.
   task automatic issue(input logic [7:0] code, output int cnt);
      @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
      @(negedge clk); cmd_valid = 1'b0;
      cnt = 0;
      for (int k = 0; k < 200; k++) begin
         if (done) return;
         if (busy) cnt++;
         @(negedge clk);
      end
      cnt = -1;
   endtask

   task automatic ack();
      @(negedge clk); int_ack = 1'b1;
      @(negedge clk); int_ack = 1'b0;
   endtask

   // Reference model built from R3, R4, R5, R7 and R8.
   task automatic model(input logic [7:0] code, input int lo_in, input int hi_in,
                        output int cnt, output logic err);
      int lo = lo_in, hi = hi_in;
      logic [2:0] tgt;
      cnt = 0; err = 1'b0;
      if (code == 8'h27) begin lo = 0; hi = NU - 1; end
      tgt = (code == 8'h2A) ? 3'b010 : (code == 8'h2C) ? 3'b001 : 3'b100;
      for (int b = lo; b <= hi; b++) begin
         cnt++;
         if (b >= NU) begin err = 1'b1; break; end
         if ((code == 8'h2C) ? (exp_st[b] != 3'b100) : (exp_st[b] != 3'b001)) begin
            exp_st[b]  = tgt;
            exp_status = {13'd0, tgt};
         end
      end
   endtask

   task automatic compare_all(input string req);
      for (int i = 0; i < NB; i++) begin
         @(negedge clk); query_idx = IW'(i);
         #1;
         check(query_state == exp_st[i], req, $sformatf("block %0d state", i),
               query_state, exp_st[i]);
      end
   endtask

   initial begin
      int cnt, ecnt;
      logic eerr;
      for (int i = 0; i < NB; i++) exp_st[i] = (i < NU) ? 3'b010 : 3'b000;
      exp_status = 16'h0002;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state, R1 encoding of locked and of absent entries
      check(wp_status == 16'h0002, "R2", "wp_status", wp_status, 16'h0002);
      check({busy, done, cmd_err, int_flag} == 4'b0, "R2", "flags",
            {busy, done, cmd_err, int_flag}, 0);
      compare_all("R1");

      // R6 masking and start-to-end copy
      @(negedge clk); start_wr = 1'b1; addr_wdata = 16'h0013;
      @(negedge clk); start_wr = 1'b0;
      check(start_addr == 4'd3, "R6", "start mask", start_addr, 3);
      check(end_addr == 4'd3, "R6", "end copy", end_addr, 3);
      end_wr = 1'b1; addr_wdata = 16'h00FE;
      @(negedge clk); end_wr = 1'b0;
      check(end_addr == 4'd14, "R6", "end mask", end_addr, 14);
      check(start_addr == 4'd3, "R6", "start kept", start_addr, 3);

      // Vector table: R3 R4 R5 R7 R8 R9 R11
      for (int v = 0; v < NVEC; v++) begin
         set_range(int'(VEC[v][23:16]), int'(VEC[v][15:8]));
         model(VEC[v][7:0], int'(VEC[v][23:16]), int'(VEC[v][15:8]), ecnt, eerr);
         issue(VEC[v][7:0], cnt);
         check(cnt == ecnt, "R9", $sformatf("vec %0d busy cycles", v), cnt, ecnt);
         check(cmd_err == eerr, "R7", $sformatf("vec %0d cmd_err", v), cmd_err, eerr);
         check(wp_status == exp_status, "R8", $sformatf("vec %0d wp_status", v),
               wp_status, exp_status);
         check(int_flag == 1'b1, "R9", $sformatf("vec %0d int_flag", v), int_flag, 1);
         @(negedge clk);
         check(done == 1'b0, "R9", $sformatf("vec %0d done width", v), done, 0);
         ack();
         check({int_flag, cmd_err} == 2'b00, "R9", "ack clears", {int_flag, cmd_err}, 0);
         compare_all((v == 7) ? "R11" : (v == 2 || v == 4 || v == 6) ? "R5" :
                     (v == 8) ? "R4" : "R3");
      end

      // R3: an unrecognised code has no effect
      @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h55;
      @(negedge clk); cmd_valid = 1'b0;
      check(busy == 1'b0 && done == 1'b0, "R3", "unknown code busy/done",
            {busy, done}, 0);
      @(negedge clk);
      check(int_flag == 1'b0, "R3", "unknown code int", int_flag, 0);
      check(wp_status == exp_status, "R3", "unknown code status", wp_status, exp_status);
      compare_all("R3");

      // R10: a command strobed while busy is ignored
      set_range(4, 6);
      model(8'h23, 4, 6, ecnt, eerr);
      @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h23;
      @(negedge clk); cmd_code = 8'h2C;
      check(busy == 1'b1, "R10", "busy during sweep", busy, 1);
      @(negedge clk); cmd_valid = 1'b0;
      cnt = 0;
      while (!done && cnt < 200) begin @(negedge clk); cnt++; end
      check(cnt < 200, "R10", "sweep finished", cnt, 0);
      @(negedge clk);
      check(busy == 1'b0, "R10", "no second sweep", busy, 0);
      check(wp_status == exp_status, "R10", "wp_status", wp_status, exp_status);
      compare_all("R10");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule